// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the D+/D- pair. Every bit takes a fixed number of system clocks, ten by default. A start request either names a byte count for a data packet or carries a single handshake PID. The block then enables its output drivers and holds the idle J level for one bit time. Next it sends the sync byte and the packet bytes, NRZI-encoded, least significant bit first, with a stuffed bit inserted after every run of six ones. It ends the packet with a single-ended zero, drives J for one more bit time, and then releases the drivers.

Data packet bytes come from an external buffer through a registered read port. The block issues each read one bit time before the byte is needed, so a packet goes out with no gap between bytes. A one-cycle commit strobe marks the end of every data packet, and the surrounding logic uses it to make a pending device address active. Handshake packets never raise the strobe. CRC generation and the choice of PID belong to the surrounding logic.

Top module: `usb_ls_tx`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, usb_oe, busy, addr_commit and buf_rd are 0 and usb_dp = usb_dm = 0. Reset taken in the middle of a packet drops usb_oe after one edge.
- R2: An accepted start raises usb_oe and busy at the next clock edge. For one bit time the lines then carry J (usb_dp = 0, usb_dm = 1) before the first sync bit.
- R3: The packet begins with the sync byte 0x80. Every byte goes out LSb first. For a data packet the total byte count is byte_count clamped into the range 2 to 12, and this count includes the sync byte. Data bytes come from buffer addresses 0, 1, 2 and so on, in that order.
- R4: Line coding is NRZI. A 0 bit toggles the pair between J and K (K is usb_dp = 1, usb_dm = 0) and a 1 bit holds it, so the first sync bit produces K.
- R5: After six consecutive 1 bits, including runs that cross byte boundaries and a run that ends on the last bit, one extra toggle is inserted and the run count restarts.
- R6: Every bit, stuffed bits included, holds the line for exactly BIT_CLKS clocks. Every level run inside a packet is therefore a multiple of BIT_CLKS.
- R7: The last bit is followed by SE0 (both lines 0) for 2 bit times and then by J for 1 bit time. After that, usb_oe and busy fall together and both lines are 0.
- R8: start_hsk sends the sync byte plus hsk_pid and makes no buffer reads. If start_hsk and start_data are high together, the handshake wins.
- R9: addr_commit pulses for exactly one cycle, in the first SE0 cycle, and only for data packets.
- R10: Start requests are ignored while busy is high. They do not change the packet in flight and are not queued.
- R11: A data packet makes exactly count-1 buffer reads. Each read goes out at the start of the last bit of the preceding byte, and its data returns on buf_data one cycle after buf_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_data | input | 1 | Start a data packet, honoured only when idle |
| start_hsk | input | 1 | Start a handshake packet, honoured only when idle; wins over start_data |
| byte_count | input | 4 | Data packet byte count including sync, clamped to 2..12 |
| hsk_pid | input | 8 | PID byte sent by a handshake packet |
| buf_rd | output | 1 | Buffer read strobe, one cycle |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_data | input | 8 | Buffer read data, valid the cycle after buf_rd |
| usb_dp | output | 1 | D+ drive level |
| usb_dm | output | 1 | D- drive level |
| usb_oe | output | 1 | Pair output enable |
| busy | output | 1 | High from an accepted start until release |
| addr_commit | output | 1 | One-cycle strobe at EOP of a data packet |

## Verification
A fault in the ones-run counter or in the line-state register shows up one bit time later as a wrong level at the mid-bit sample. A decoder that follows NRZI and stuffing then reports a wrong byte or a missing stuff toggle. A fault in the bit timer or in the byte prefetch changes the length of a level run or the time at which a byte becomes ready. The run-length monitor catches this within the bit concerned. A fault in the EOP sequencing changes how long SE0 or the final J lasts, or when usb_oe falls, so it shows in the last three bit times of the packet.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
    localparam int DEF_BIT_CLKS = 10;
    localparam int STUFF_RUN    = 6;
    localparam int BYTE_W       = 8;
    localparam int CNT_W        = 4;
    localparam int SLOT_W       = $clog2(BYTE_W + 1);
    localparam int MIN_BYTES    = 2;
    localparam int MAX_BYTES    = 12;
    localparam int EOP_SE0_BITS = 2;
    localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_PRE,
        TX_BITS,
        TX_SE0,
        TX_EOPJ
    } tx_state_e;

    // byte under serialisation and the number of its bits still to go
    typedef struct packed {
        logic [BYTE_W-1:0] bits;
        logic [SLOT_W-1:0] left;
    } tx_slot_t;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] req);
        if (req < CNT_W'(MIN_BYTES)) return CNT_W'(MIN_BYTES);
        if (req > CNT_W'(MAX_BYTES)) return CNT_W'(MAX_BYTES);
        return req;
    endfunction
endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
    parameter int BIT_CLKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/usbtx_line_coder.sv
module usbtx_line_coder #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  logic data_bit,
    output logic need_stuff,
    output logic line_k
);
    localparam int OW = $clog2(STUFF_RUN + 1);

    logic [OW-1:0] ones;

    assign need_stuff = (ones == OW'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ones   <= '0;
            line_k <= 1'b0;
        end else if (shift_en) begin
            if (need_stuff || !data_bit) begin
                line_k <= ~line_k;
                ones   <= '0;
            end else begin
                ones   <= ones + OW'(1);
            end
        end
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ones <= OW'(STUFF_RUN)); // R5
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usbtx_pkg::*;
#(
    parameter int BIT_CLKS = DEF_BIT_CLKS,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_data,
    input  logic              start_hsk,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [BYTE_W-1:0] hsk_pid,
    output logic              buf_rd,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [BYTE_W-1:0] buf_data,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy,
    output logic              addr_commit
);
    localparam int SE0W = (EOP_SE0_BITS > 1) ? $clog2(EOP_SE0_BITS) : 1;

    tx_state_e         state;
    logic              is_data;
    tx_slot_t          cur, eff;
    logic [BYTE_W-1:0] nxt;
    logic [CNT_W-1:0]  bytes_left, left_after;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_ptr;
    logic [SE0W-1:0]   se0_bits;

    logic idle, go_hsk, go_data, go, bit_tick, serializing;
    logic load_next, have_bit, fetch, need_stuff, line_k, coder_shift;

    assign idle        = (state == TX_IDLE);
    assign go_hsk      = idle && start_hsk;
    assign go_data     = idle && start_data && !start_hsk;
    assign go          = go_hsk || go_data;
    assign serializing = (state == TX_PRE) || (state == TX_BITS);

    usbtx_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk(clk), .rst(rst), .restart(go), .run(!idle), .tick(bit_tick)
    );

    always_comb begin
        load_next  = (cur.left == '0) && (bytes_left != '0);
        eff        = load_next ? '{bits: nxt, left: SLOT_W'(BYTE_W)} : cur;
        have_bit   = (eff.left != '0);
        left_after = load_next ? bytes_left - CNT_W'(1) : bytes_left;
        fetch      = is_data && (eff.left == SLOT_W'(1)) && (left_after != '0);
    end

    assign coder_shift = bit_tick && serializing && (need_stuff || have_bit);

    usbtx_line_coder #(.STUFF_RUN(STUFF_RUN)) u_coder (
        .clk(clk), .rst(rst), .clear(go), .shift_en(coder_shift),
        .data_bit(eff.bits[0]), .need_stuff(need_stuff), .line_k(line_k)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TX_IDLE;
            is_data     <= 1'b0;
            cur         <= '0;
            nxt         <= '0;
            bytes_left  <= '0;
            rd_pend     <= 1'b0;
            rd_ptr      <= '0;
            se0_bits    <= '0;
            buf_rd      <= 1'b0;
            buf_addr    <= '0;
            addr_commit <= 1'b0;
        end else begin
            buf_rd      <= 1'b0;
            addr_commit <= 1'b0;
            rd_pend     <= buf_rd;
            if (rd_pend) nxt <= buf_data;
            unique case (state)
                TX_IDLE: begin
                    if (go) begin
                        state   <= TX_PRE;
                        is_data <= go_data;
                        cur     <= '{bits: SYNC_PATTERN, left: SLOT_W'(BYTE_W)};
                        rd_ptr  <= '0;
                        if (go_hsk) begin
                            bytes_left <= CNT_W'(1);
                            nxt        <= hsk_pid;
                        end else begin
                            bytes_left <= clamp_count(byte_count) - CNT_W'(1);
                        end
                    end
                end
                TX_PRE, TX_BITS: begin
                    if (bit_tick) begin
                        state <= TX_BITS;
                        if (!need_stuff) begin
                            if (have_bit) begin
                                cur        <= '{bits: eff.bits >> 1, left: eff.left - SLOT_W'(1)};
                                bytes_left <= left_after;
                                if (fetch) begin
                                    buf_rd   <= 1'b1;
                                    buf_addr <= rd_ptr;
                                    rd_ptr   <= rd_ptr + ADDR_W'(1);
                                end
                            end else begin
                                state       <= TX_SE0;
                                se0_bits    <= '0;
                                addr_commit <= is_data;
                            end
                        end
                    end
                end
                TX_SE0: begin
                    if (bit_tick) begin
                        if (se0_bits == SE0W'(EOP_SE0_BITS - 1)) state <= TX_EOPJ;
                        else se0_bits <= se0_bits + SE0W'(1);
                    end
                end
                TX_EOPJ: begin
                    if (bit_tick) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign usb_oe = !idle;
    assign busy   = !idle;
    assign usb_dp = (state == TX_BITS) && line_k;
    assign usb_dm = (state == TX_PRE) || (state == TX_EOPJ) || ((state == TX_BITS) && !line_k);

    AST_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_tick) |=> $stable({usb_dp, usb_dm})); // R6
    AST_COMMIT_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        addr_commit |-> (state == TX_SE0) && is_data); // R9
    AST_HSK_NO_READ: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> is_data); // R8
    AST_BYTE_READY: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && serializing && load_next && !need_stuff) |-> (!rd_pend && !buf_rd)); // R11
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(usb_oe) |-> !usb_dp && !usb_dm && !busy); // R7
endmodule

// File: tb/sim_usb_ls_tx.sv
`timescale 1ns/1ps
module sim_usb_ls_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_data = 1'b0;
    logic       start_hsk = 1'b0;
    logic [3:0] byte_count = '0;
    logic [7:0] hsk_pid = '0;
    logic       buf_rd;
    logic [3:0] buf_addr;
    logic [7:0] buf_data = '0;
    logic       usb_dp, usb_dm, usb_oe, busy, addr_commit;

    int   checks = 0;
    int   errors = 0;
    int   commits = 0;
    int   reads = 0;
    logic done = 1'b0;
    logic mon_en = 1'b1;
    logic [7:0] mem [16];

    always #2.5 clk = ~clk;

    usb_ls_tx u0 (
        .clk(clk), .rst(rst), .start_data(start_data), .start_hsk(start_hsk),
        .byte_count(byte_count), .hsk_pid(hsk_pid), .buf_rd(buf_rd),
        .buf_addr(buf_addr), .buf_data(buf_data), .usb_dp(usb_dp),
        .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy), .addr_commit(addr_commit)
    );

    always @(posedge clk) begin
        if (buf_rd) buf_data <= mem[buf_addr];
        if (addr_commit) commits++;
        if (buf_rd) reads++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // level run-length monitor: bit timing (R6) and EOP lengths (R7)
    logic [1:0] last_ln = '0;
    int   lrun = 0;
    logic was_oe = 1'b0;
    always @(negedge clk) begin
        if (rst || !mon_en) begin
            was_oe = 1'b0;
        end else begin
            if (usb_oe) begin
                if (!was_oe) lrun = 1;
                else if ({usb_dp, usb_dm} != last_ln) begin
                    chk(lrun % 10 == 0, "R6", lrun, (lrun / 10) * 10);
                    if (last_ln == 2'b00) chk(lrun == 20, "R7 se0 length", lrun, 20);
                    lrun = 1;
                end else lrun++;
            end else if (was_oe) begin
                chk(lrun == 10, "R7 final J length", lrun, 10);
            end
            last_ln = {usb_dp, usb_dm};
            was_oe  = usb_oe;
        end
    end

    // {hsk, count_in, expected_total, pid, 11 data bytes (byte0 in LSBs)}
    localparam int NV = 8;
    localparam logic [104:0] VEC [NV] = '{
        {1'b1, 4'd0,  4'd2,  8'hD2, 88'h0},
        {1'b1, 4'd9,  4'd2,  8'h5A, 88'h0},
        {1'b0, 4'd4,  4'd4,  8'h00, 88'hFF00C3},
        {1'b0, 4'd2,  4'd2,  8'h00, 88'hFC},
        {1'b0, 4'd12, 4'd12, 8'h00, 88'h00FFFFEFCDAB8967452301},
        {1'b0, 4'd0,  4'd2,  8'h00, 88'h7E},
        {1'b0, 4'd15, 4'd12, 8'h00, 88'hFFFFFFFFFFFFFFFFFFFFFF},
        {1'b0, 4'd1,  4'd2,  8'h00, 88'h00}
    };

    task automatic run_packet(input logic hsk, input logic dat, input logic [3:0] cnt,
                              input logic [7:0] pid, input int exp_n, input logic exp_hsk);
        int nbytes = 0, nbits = 0, run = 0, se0n = 0, phase = 0, stuff_err = 0;
        logic jn = 1'b0;
        logic prev = 1'b0;
        logic bitv;
        logic [7:0] cur = '0;
        logic [7:0] got [16];
        commits = 0;
        reads = 0;
        start_hsk = hsk; start_data = dat; byte_count = cnt; hsk_pid = pid;
        @(negedge clk);
        start_hsk = 1'b0; start_data = 1'b0;
        chk(usb_oe && busy, "R2 enable on start", {usb_oe, busy}, 3);
        repeat (4) @(negedge clk);
        chk(!usb_dp && usb_dm, "R2 leading J", {usb_dp, usb_dm}, 1);
        for (int s = 0; s < 400 && phase < 3; s++) begin
            repeat (10) @(negedge clk);
            case (phase)
                0: begin
                    if (!usb_dp && !usb_dm) begin
                        if (run == 6) stuff_err++;
                        se0n = 1; phase = 1;
                    end else begin
                        if (nbytes == 0 && nbits == 0) chk(usb_dp, "R4 first sync bit is K", usb_dp, 1);
                        bitv = (usb_dp == prev);
                        prev = usb_dp;
                        if (run == 6) begin
                            if (bitv) stuff_err++;
                            run = 0;
                        end else begin
                            run = bitv ? run + 1 : 0;
                            cur = {bitv, cur[7:1]};
                            nbits++;
                            if (nbits == 8) begin
                                if (nbytes < 16) got[nbytes] = cur;
                                nbytes++;
                                nbits = 0;
                            end
                        end
                    end
                end
                1: begin
                    if (!usb_dp && !usb_dm) se0n++;
                    else begin jn = usb_dm && !usb_dp; phase = 2; end
                end
                default: begin
                    chk(!usb_oe && !busy && !usb_dp && !usb_dm, "R7 released",
                        {usb_oe, busy, usb_dp, usb_dm}, 0);
                    phase = 3;
                end
            endcase
        end
        chk(phase == 3, "R7 packet ended", phase, 3);
        chk(nbits == 0 && nbytes == exp_n, "R3 byte total", nbytes, exp_n);
        chk(nbytes > 0 && got[0] == 8'h80, "R3 sync byte", got[0], 8'h80);
        for (int i = 1; i < exp_n && i < nbytes && i < 16; i++) begin
            chk(got[i] == (exp_hsk ? pid : mem[i-1]), "R3/R11 byte content", got[i],
                exp_hsk ? pid : mem[i-1]);
        end
        chk(stuff_err == 0, "R5 stuffing", stuff_err, 0);
        chk(se0n == 2, "R7 se0 bits", se0n, 2);
        chk(jn, "R7 J after se0", jn, 1);
        chk(commits == (exp_hsk ? 0 : 1), "R9 commit count", commits, exp_hsk ? 0 : 1);
        chk(reads == (exp_hsk ? 0 : exp_n - 1), "R8/R11 buffer reads", reads, exp_hsk ? 0 : exp_n - 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!usb_oe && !busy && !usb_dp && !usb_dm && !addr_commit && !buf_rd, "R1 in reset",
            {usb_oe, busy, usb_dp, usb_dm}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!usb_oe && !busy && !usb_dp && !usb_dm && !addr_commit && !buf_rd, "R1 after reset",
            {usb_oe, busy, usb_dp, usb_dm}, 0);

        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 11; i++) mem[i] = VEC[v][8*i +: 8];
            fork
                run_packet(VEC[v][104], !VEC[v][104], VEC[v][103:100], VEC[v][95:88],
                           int'(VEC[v][99:96]), VEC[v][104]);
                begin
                    // R10: a start request in mid-packet must be ignored
                    repeat (30) @(negedge clk);
                    start_data = 1'b1; byte_count = 4'd7;
                    @(negedge clk);
                    start_data = 1'b0;
                end
            join
            repeat (3) @(negedge clk);
            chk(!busy && !usb_oe, "R10 no queued packet", {busy, usb_oe}, 0);
        end

        // R8: both starts at once, the handshake wins
        for (int i = 0; i < 11; i++) mem[i] = 8'hA5;
        run_packet(1'b1, 1'b1, 4'd5, 8'h4B, 2, 1'b1);
        repeat (3) @(negedge clk);

        // R1: reset during a packet
        mon_en = 1'b0;
        start_data = 1'b1; byte_count = 4'd6;
        @(negedge clk);
        start_data = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!usb_oe && !busy && !usb_dp && !usb_dm, "R1 mid-packet reset",
            {usb_oe, busy, usb_dp, usb_dm}, 0);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;
        for (int i = 0; i < 11; i++) mem[i] = 8'(8'h3C + i);
        run_packet(1'b0, 1'b1, 4'd3, 8'h00, 3, 1'b0);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule